// File: doc/BRIEF.md
# Temperature Conversion Rate Scheduler

This block decides when a two-channel temperature sensor runs a conversion. In free-running mode it starts conversions at a fixed spacing chosen by a rate byte. A standby control stops that pacing, and a one-shot strobe requests a single conversion. The converter is modelled only by its duration, which is a fixed number of ticks of a millisecond strobe. The block reports a busy level, a one-cycle start pulse and a one-cycle pulse that marks fresh results.

Only the three low bits of the rate byte matter. Each code halves the spacing of the one before it, so eight rates run from one conversion per sixteen seconds up to eight per second. At the fastest rate the spacing equals the conversion time, and conversions then follow each other with no gap. A one-shot that arrives while idle starts a conversion at once. A one-shot that arrives while a conversion runs is discarded.

Top module: `conv_rate_sched`

## Requirements
- R1: Reset sets the rate code to 2, which gives a start-to-start spacing of BASE_TICKS/4 ticks. While reset is high, busy_o, start_o and valid_o are low. A conversion starts on its own in the first cycle after reset is released (start_o high in that cycle).
- R2: In run mode (stop_i low), with code k held in rate_data_i[2:0], consecutive start_o pulses lie exactly BASE_TICKS >> k ticks apart.
- R3: Bits [7:3] of a rate write have no effect on the spacing.
- R4: valid_o is a one-cycle pulse. It rises in the cycle after the CONV_TICKS-th tick counted from the start_o cycle, where the start_o cycle's own tick is included.
- R5: busy_o rises together with start_o and stays high until the cycle in which valid_o is high. In that cycle busy_o is low, unless a new conversion starts in the same cycle.
- R6: A oneshot_i pulse seen while busy_o is high is dropped, and no extra conversion follows it.
- R7: A oneshot_i pulse seen while busy_o is low gives start_o in the next cycle, in standby as well as in run mode.
- R8: While stop_i is high, no conversion starts except from a one-shot.
- R9: A 1-to-0 change of stop_i while idle gives start_o in the next cycle.
- R10: With code 7 (spacing equal to CONV_TICKS), a new start_o falls in the same cycle as valid_o, and busy_o stays high.
- R11: A rate write during a conversion does not change when that conversion ends. The new spacing takes effect from the end of the conversion, and if that spacing has already elapsed, the next start comes in the cycle after valid_o.
- R12: The conversion and spacing counters advance only in cycles where tick_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Time-base strobe, one per millisecond |
| rate_wr_i | input | 1 | Rate byte write enable |
| rate_data_i | input | RATE_W | Rate byte; bits [2:0] hold the code |
| stop_i | input | 1 | 1 = standby, 0 = run |
| oneshot_i | input | 1 | Single-conversion request strobe |
| busy_o | output | 1 | Conversion in progress |
| start_o | output | 1 | One-cycle pulse when a conversion starts |
| valid_o | output | 1 | One-cycle pulse when results are ready |

## Verification
The bench builds the block with CONV_TICKS=4 and BASE_TICKS=512. With these values the slowest code spaces starts 512 cycles apart, so all eight codes and the back-to-back case at code 7 can be measured exactly with ticks held high. A short conversion also lets a rate write land inside a conversion and lets a one-shot hit a busy converter within a few cycles. One test drives ticks only on every third cycle, to show that the timing counts ticks and not clock cycles.

// File: rtl/crs_pkg.sv
package crs_pkg;

  // Spacing in ticks for a rate code: each step halves the slowest interval.
  function automatic int unsigned interval_of(input int unsigned base, input int unsigned code);
    return base >> code;
  endfunction

endpackage

// File: rtl/crs_sat_counter.sv
module crs_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                        cnt_q <= '0;
    else if (clr)                   cnt_q <= '0;
    else if (inc && (cnt_q != '1))  cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/crs_rate_reg.sv
module crs_rate_reg #(
  parameter int RATE_W     = 8,
  parameter int CODE_W     = 3,
  parameter int RATE_RESET = 2,
  parameter int BASE_TICKS = 16000,
  parameter int CNT_W      = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              load_en,
  output logic [CNT_W-1:0]  interval_o
);

  localparam int NCODES = 2 ** CODE_W;

  logic [CNT_W-1:0]  lut [NCODES];
  logic [CODE_W-1:0] code_q;
  logic [CNT_W-1:0]  lim_q;

  for (genvar k = 0; k < NCODES; k++) begin : g_lut
    assign lut[k] = CNT_W'(crs_pkg::interval_of(BASE_TICKS, k));
  end

  always_ff @(posedge clk) begin
    if (rst)        code_q <= CODE_W'(RATE_RESET);
    else if (wr_en) code_q <= wr_code;
  end

  // The live interval follows the stored code only outside a conversion.
  always_ff @(posedge clk) begin
    if (rst)          lim_q <= CNT_W'(crs_pkg::interval_of(BASE_TICKS, RATE_RESET));
    else if (load_en) lim_q <= lut[code_q];
  end

  assign interval_o = lim_q;

endmodule

// File: rtl/conv_rate_sched.sv
module conv_rate_sched #(
  parameter int RATE_W     = 8,
  parameter int CODE_W     = 3,
  parameter int RATE_RESET = 2,
  parameter int CONV_TICKS = 125,
  parameter int BASE_TICKS = 16000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              rate_wr_i,
  input  logic [RATE_W-1:0] rate_data_i,
  input  logic              stop_i,
  input  logic              oneshot_i,
  output logic              busy_o,
  output logic              start_o,
  output logic              valid_o
);

  localparam int CNT_W  = $clog2(BASE_TICKS + 1);
  localparam int CONV_W = $clog2(CONV_TICKS + 1);

  logic              busy_q, start_q, valid_q, por_q, stop_prev_q;
  logic [CONV_W-1:0] conv_cnt;
  logic [CNT_W-1:0]  intv_cnt, intv_lim;
  logic              conv_end, intv_due, auto_go, run_edge, start_now;
  logic              rate_hi_unused;

  assign rate_hi_unused = ^rate_data_i[RATE_W-1:CODE_W];

  crs_rate_reg #(
    .RATE_W(RATE_W), .CODE_W(CODE_W), .RATE_RESET(RATE_RESET),
    .BASE_TICKS(BASE_TICKS), .CNT_W(CNT_W)
  ) u_rate (
    .clk(clk), .rst(rst),
    .wr_en(rate_wr_i), .wr_code(rate_data_i[CODE_W-1:0]),
    .load_en(~busy_q | conv_end),
    .interval_o(intv_lim)
  );

  crs_sat_counter #(.W(CONV_W)) u_conv_cnt (
    .clk(clk), .rst(rst), .clr(start_now), .inc(busy_q & tick_i), .cnt_o(conv_cnt)
  );

  crs_sat_counter #(.W(CNT_W)) u_intv_cnt (
    .clk(clk), .rst(rst), .clr(start_now), .inc(tick_i), .cnt_o(intv_cnt)
  );

  assign conv_end  = busy_q & tick_i & (conv_cnt == CONV_W'(CONV_TICKS - 1));
  assign intv_due  = tick_i & (intv_cnt >= (intv_lim - CNT_W'(1)));
  assign auto_go   = ~stop_i & intv_due & (~busy_q | conv_end);
  assign run_edge  = stop_prev_q & ~stop_i;
  // Idle-only sources: power-up, one-shot, leaving standby. Busy drops one-shots.
  assign start_now = (~busy_q & (por_q | oneshot_i | run_edge)) | auto_go;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      start_q     <= 1'b0;
      valid_q     <= 1'b0;
      por_q       <= 1'b1;
      stop_prev_q <= 1'b0;
    end else begin
      start_q     <= start_now;
      valid_q     <= conv_end;
      stop_prev_q <= stop_i;
      if (start_now) por_q <= 1'b0;
      if (start_now)     busy_q <= 1'b1;
      else if (conv_end) busy_q <= 1'b0;
    end
  end

  assign busy_o  = busy_q;
  assign start_o = start_q;
  assign valid_o = valid_q;

endmodule

// File: rtl/conv_rate_sched_chk.sv
module conv_rate_sched_chk #(
  parameter int CONV_TICKS = 125
) (
  input logic clk,
  input logic rst,
  input logic tick_i,
  input logic stop_i,
  input logic oneshot_i,
  input logic busy_o,
  input logic start_o,
  input logic valid_o
);

  localparam int CW = $clog2(CONV_TICKS + 2);

  logic [CW-1:0] ticks_q;

  always_ff @(posedge clk) begin
    if (rst)          ticks_q <= '0;
    else if (start_o) ticks_q <= tick_i ? CW'(1) : '0;
    else if (busy_o && tick_i && (ticks_q != '1)) ticks_q <= ticks_q + CW'(1);
  end

  a_r5_busy_with_start: assert property (@(posedge clk) disable iff (rst)
    start_o |-> busy_o);

  a_r5_busy_rise_is_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> start_o);

  a_r5_valid_ends_busy: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !start_o) |-> !busy_o);

  a_r4_conv_duration: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (ticks_q == CW'(CONV_TICKS)));

  a_r6_oneshot_dropped: assert property (@(posedge clk) disable iff (rst)
    (busy_o && stop_i && oneshot_i) |=> !start_o);

endmodule

bind conv_rate_sched conv_rate_sched_chk #(.CONV_TICKS(CONV_TICKS)) u_chk (
  .clk(clk), .rst(rst), .tick_i(tick_i), .stop_i(stop_i), .oneshot_i(oneshot_i),
  .busy_o(busy_o), .start_o(start_o), .valid_o(valid_o)
);

// File: tb/tb_conv_rate_sched.sv
module tb_conv_rate_sched;

  localparam int CONV = 4;
  localparam int BASE = 512;
  localparam int NV   = 10;
  localparam logic [7:0] VR [NV] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04,
                                     8'h05, 8'h06, 8'hF8, 8'hAB, 8'h07};
  localparam int         VE [NV] = '{512, 256, 128, 64, 32, 16, 8, 512, 64, 4};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, tick = 1'b1, wr = 1'b0, stop = 1'b0, os = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic busy, start, valid;
  logic s_busy, s_start, s_valid;
  int checks = 0, fails = 0, phase = 0, ticks_seen = 0;
  bit done = 1'b0, sparse = 1'b0;

  conv_rate_sched #(.CONV_TICKS(CONV), .BASE_TICKS(BASE)) dut (
    .clk(clk), .rst(rst), .tick_i(tick), .rate_wr_i(wr), .rate_data_i(wdata),
    .stop_i(stop), .oneshot_i(os), .busy_o(busy), .start_o(start), .valid_o(valid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    if (sparse) begin
      tick  = (phase == 2);
      phase = (phase + 1) % 3;
    end else tick = 1'b1;
    if (tick) ticks_seen++;
    @(negedge clk);
    s_busy = busy; s_start = start; s_valid = valid;
  endtask

  task automatic gap_to_start(output int n);
    n = 0;
    do begin step(); n++; end while (!s_start && n < 3000);
  endtask

  task automatic write_rate(input logic [7:0] v);
    wr = 1'b1; wdata = v; step(); wr = 1'b0;
    repeat (3) step();
  endtask

  initial begin
    int n, m, cnt;
    bit ok;
    // R1: reset state and power-on conversion at default rate
    repeat (3) step();
    check(!s_busy && !s_start && !s_valid, "R1 reset outputs", {s_busy, s_start, s_valid}, 0);
    rst = 1'b0;
    step();
    check(s_start, "R1 power-on start", s_start, 1);
    // R4/R5: duration and busy window of this conversion
    m = 0; ok = 1'b1;
    do begin step(); m++; if (!s_valid && !s_busy) ok = 1'b0; end while (!s_valid && m < 50);
    check(m == CONV, "R4 conversion ticks", m, CONV);
    check(ok && !s_busy, "R5 busy window", s_busy, 0);
    gap_to_start(n);
    check(n + m == 128, "R1 default spacing", n + m, 128);

    // R2/R3/R9/R10: table of rate bytes
    for (int i = 0; i < NV; i++) begin
      stop = 1'b1;
      repeat (6) step();
      write_rate(VR[i]);
      stop = 1'b0;
      step();
      check(s_start, "R9 run start", s_start, 1);
      gap_to_start(n);
      check(n == VE[i], (VR[i][7:3] != 0) ? "R3 upper bits ignored" : "R2 spacing", n, VE[i]);
      if (VR[i][2:0] == 3'd7)
        check(s_valid && s_busy, "R10 back to back", {s_valid, s_busy}, 3);
    end

    // R8: standby stops automatic starts
    stop = 1'b1;
    repeat (6) step();
    cnt = 0;
    repeat (100) begin step(); if (s_start) cnt++; end
    check(cnt == 0, "R8 standby", cnt, 0);

    // R7 then R6
    os = 1'b1; step(); os = 1'b0;
    check(s_start, "R7 one-shot idle", s_start, 1);
    step();
    os = 1'b1; step(); os = 1'b0;
    cnt = 0;
    repeat (12) begin step(); if (s_start) cnt++; end
    check(cnt == 0, "R6 one-shot dropped", cnt, 0);

    // R11: rate write inside a conversion
    write_rate(8'h00);
    stop = 1'b0;
    step();
    wr = 1'b1; wdata = 8'h07; step(); wr = 1'b0;
    m = 1;
    while (!s_valid && m < 50) begin step(); m++; end
    check(m == CONV, "R11 conversion undisturbed", m, CONV);
    n = m;
    while (!s_start && n < 600) begin step(); n++; end
    check(n == CONV + 1, "R11 new spacing", n, CONV + 1);
    stop = 1'b1;
    repeat (8) step();

    // R12: sparse ticks
    sparse = 1'b1; phase = 0;
    os = 1'b1; step(); os = 1'b0;
    check(s_start, "R12 start", s_start, 1);
    ticks_seen = 0; m = 0;
    do begin step(); m++; end while (!s_valid && m < 100);
    check(ticks_seen == CONV, "R12 ticks per conversion", ticks_seen, CONV);
    check(m >= 3 * CONV - 2, "R12 cycles per conversion", m, 3 * CONV - 2);
    sparse = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule